// File: doc/BRIEF.md
# Integer Add/Compare Execution Unit with Overflow Trap Flag

This block is the integer arithmetic slice of a load/store RISC core's execute stage. It adds and subtracts 32-bit register operands, or a register and a 16-bit immediate, and it compares two operands as signed or unsigned integers. Each arithmetic operation has two forms. The trapping form raises an overflow flag when the signed result does not fit in 32 bits. The non-trapping form returns the same modular result and never raises the flag.

The arithmetic is purely combinational. A thin registered wrapper captures the result, the overflow flag and a commit indication on every clock edge, so each operation is visible one cycle after it is presented. When the flag is raised, the wrapped value still appears on the result. The commit indication goes low so that the core knows not to write it back. Handling the exception is left to the surrounding core.

Top module: `int_alu_reg`

## Requirements
- R1: When `use_imm_i` is 1, the second operand is `imm_i` sign-extended to 32 bits (bit 15 copied into bits 31..16). Otherwise it is `rt_i`.
- R2: Operation codes 0 (trapping add) and 2 (trapping subtract, `rs_i` minus the second operand) set `ovf_o` exactly when the mathematically exact signed result lies outside -2^31 .. 2^31-1.
- R3: Operation codes 1 (non-trapping add) and 3 (non-trapping subtract) produce the same 32-bit result as codes 0 and 2 and never set `ovf_o`.
- R4: Every add or subtract returns the result modulo 2^32 on `result_o`, including when `ovf_o` is set. An unsigned sum of 2^32 or more wraps exactly once.
- R5: Operation code 4 returns 1 when `rs_i` is less than the second operand as two's-complement numbers, and 0 otherwise. Bits 31..1 of the result are always 0.
- R6: Operation code 5 returns 1 when `rs_i` is less than the second operand as unsigned numbers, and 0 otherwise. In immediate form, the sign-extended 32-bit pattern is the value compared.
- R7: Operation codes 6 and 7 are reserved. They return a result of 0 with `ovf_o` at 0.
- R8: After the first clock edge that follows a reset, `commit_ok_o` is the inverse of `ovf_o`. A flagged result is never marked committable.
- R9: Outputs are registered. Operands presented before a rising edge appear on the outputs after that edge. A synchronous active-high reset clears `result_o`, `ovf_o` and `commit_ok_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0 add, 1 add no-trap, 2 sub, 3 sub no-trap, 4 signed less-than, 5 unsigned less-than, 6..7 reserved) |
| use_imm_i | input | 1 | Selects the sign-extended immediate as the second operand |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed-overflow trap flag |
| commit_ok_o | output | 1 | Registered indication that the result may be written back |

## Verification
The assertions assume that every input is at a defined 0 or 1 at each rising edge. They also assume that the operation code, operand-select bit and operands sampled one edge earlier are the ones that produced the current outputs. This requires the inputs to be held steady across each edge rather than changed at it. To keep within these assumptions, the stimulus changes inputs only on falling edges and holds reset high with defined operands over the first edges. Every operation code, including the reserved ones, is driven in both register and immediate form.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN = 32;
    localparam int IMMW = 16;
    localparam int OPW  = 3;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 3'd0,
        OP_ADDU = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBU = 3'd3,
        OP_SLT  = 3'd4,
        OP_SLTU = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            ovf;
    } alu_res_t;

    function automatic logic op_traps(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic op_subtracts(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SUBU);
    endfunction

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDU) || (op == OP_SUB) || (op == OP_SUBU);
    endfunction

endpackage

// File: rtl/operand_sel.sv
module operand_sel #(
    parameter int W    = 32,
    parameter int IW   = 16
) (
    input  logic [W-1:0]  rt,
    input  logic [IW-1:0] imm,
    input  logic          use_imm,
    output logic [W-1:0]  opnd_b
);
    localparam int EXT = W - IW;

    logic [W-1:0] imm_ext;

    generate
        if (EXT > 0) begin : g_ext
            assign imm_ext = {{EXT{imm[IW-1]}}, imm};
        end else begin : g_noext
            assign imm_ext = imm[W-1:0];
        end
    endgenerate

    assign opnd_b = use_imm ? imm_ext : rt;
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         sovf
);
    logic [W-1:0] b_eff;
    logic [W-1:0] cin;

    always_comb begin
        b_eff = sub ? ~b : b;
        cin   = {{(W-1){1'b0}}, sub};
        sum   = a + b_eff + cin;
        sovf  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/less_than_unit.sv
module less_than_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt_s,
    output logic         lt_u
);
    always_comb begin
        lt_u = (a < b);
        if (a[W-1] != b[W-1])
            lt_s = a[W-1];
        else
            lt_s = lt_u;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
(
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  rs,
    input  logic [XLEN-1:0]  rt,
    input  logic [IMMW-1:0]  imm,
    input  logic             use_imm,
    output alu_res_t         res
);
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] sum;
    logic            sovf;
    logic            lt_s;
    logic            lt_u;

    operand_sel #(.W(XLEN), .IW(IMMW)) u_opsel (
        .rt      (rt),
        .imm     (imm),
        .use_imm (use_imm),
        .opnd_b  (opnd_b)
    );

    addsub_unit #(.W(XLEN)) u_addsub (
        .a    (rs),
        .b    (opnd_b),
        .sub  (op_subtracts(op)),
        .sum  (sum),
        .sovf (sovf)
    );

    less_than_unit #(.W(XLEN)) u_lt (
        .a    (rs),
        .b    (opnd_b),
        .lt_s (lt_s),
        .lt_u (lt_u)
    );

    always_comb begin
        res = '0;
        if (op_is_arith(op)) begin
            res.value = sum;
            res.ovf   = sovf && op_traps(op);
        end else if (op == OP_SLT) begin
            res.value = {{(XLEN-1){1'b0}}, lt_s};
        end else if (op == OP_SLTU) begin
            res.value = {{(XLEN-1){1'b0}}, lt_u};
        end
    end
endmodule

// File: rtl/int_alu_reg.sv
module int_alu_reg
    import alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPW-1:0]   op_i,
    input  logic             use_imm_i,
    input  logic [XLEN-1:0]  rs_i,
    input  logic [XLEN-1:0]  rt_i,
    input  logic [IMMW-1:0]  imm_i,
    output logic [XLEN-1:0]  result_o,
    output logic             ovf_o,
    output logic             commit_ok_o
);
    alu_res_t res_d;
    alu_res_t res_q;
    logic     commit_q;

    alu_core u_core (
        .op      (alu_op_e'(op_i)),
        .rs      (rs_i),
        .rt      (rt_i),
        .imm     (imm_i),
        .use_imm (use_imm_i),
        .res     (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q    <= '0;
            commit_q <= 1'b0;
        end else begin
            res_q    <= res_d;
            commit_q <= ~res_d.ovf;
        end
    end

    assign result_o    = res_q.value;
    assign ovf_o       = res_q.ovf;
    assign commit_ok_o = commit_q;
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker
    import alu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OPW-1:0]   op_i,
    input logic             use_imm_i,
    input logic [XLEN-1:0]  rs_i,
    input logic [XLEN-1:0]  rt_i,
    input logic [IMMW-1:0]  imm_i,
    input logic [XLEN-1:0]  result_o,
    input logic             ovf_o,
    input logic             commit_ok_o
);
    // R3: non-trapping forms never raise the flag
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(op_i) == 3'd1 || $past(op_i) == 3'd3) |-> !ovf_o);

    // R5 / R6: comparisons return only 0 or 1
    assert_cmp_bool_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(op_i) == 3'd4 || $past(op_i) == 3'd5) |-> (result_o[XLEN-1:1] == '0 && !ovf_o));

    // R7: reserved codes give zero and no flag
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(op_i) == 3'd6 || $past(op_i) == 3'd7) |-> (result_o == '0 && !ovf_o));

    // R8: a flagged result is never committable
    assert_no_commit_on_trap_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> !commit_ok_o);

    // R2: register-form add overflow needs same-sign operands and a flipped result sign
    assert_add_ovf_sign_R2: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && $past(op_i) == 3'd0 && !$past(use_imm_i)) |->
        ($past(rs_i[XLEN-1]) == $past(rt_i[XLEN-1]) && result_o[XLEN-1] != $past(rs_i[XLEN-1])));

    // R1: immediate-form add overflow uses the immediate's sign bit as the operand sign
    assert_imm_ovf_sign_R1: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && $past(op_i) == 3'd0 && $past(use_imm_i)) |->
        ($past(rs_i[XLEN-1]) == $past(imm_i[IMMW-1])));

    // R9: reset clears the outputs on the following edge
    assert_reset_clear_R9: assert property (@(posedge clk)
        $past(rst) |-> (result_o == '0 && !ovf_o && !commit_ok_o));
endmodule

bind int_alu_reg int_alu_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_i        (op_i),
    .use_imm_i   (use_imm_i),
    .rs_i        (rs_i),
    .rt_i        (rt_i),
    .imm_i       (imm_i),
    .result_o    (result_o),
    .ovf_o       (ovf_o),
    .commit_ok_o (commit_ok_o)
);

// File: tb/tb_int_alu_reg.sv
module tb_int_alu_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = 3'd0;
    logic        use_imm_i = 1'b0;
    logic [31:0] rs_i = 32'd0;
    logic [31:0] rt_i = 32'd0;
    logic [15:0] imm_i = 16'd0;
    logic [31:0] result_o;
    logic        ovf_o;
    logic        commit_ok_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    int_alu_reg dut (
        .clk(clk), .rst(rst), .op_i(op_i), .use_imm_i(use_imm_i),
        .rs_i(rs_i), .rt_i(rt_i), .imm_i(imm_i),
        .result_o(result_o), .ovf_o(ovf_o), .commit_ok_o(commit_ok_o)
    );

    task automatic check(input string req, input logic [31:0] exp_r, input logic exp_o);
        checks++;
        if (result_o !== exp_r || ovf_o !== exp_o || commit_ok_o !== ~exp_o) begin
            failures++;
            $display("FAIL %s: result=%h ovf=%b ok=%b expected result=%h ovf=%b ok=%b",
                     req, result_o, ovf_o, commit_ok_o, exp_r, exp_o, ~exp_o);
        end
    endtask

    // independent model from the requirements, using wide signed arithmetic
    task automatic model(input logic [2:0] op, input logic ui, input logic [31:0] a,
                         input logic [31:0] rt, input logic [15:0] im,
                         output logic [31:0] r, output logic o);
        logic [31:0] b;
        longint sa, sb, t;
        b  = ui ? {{16{im[15]}}, im} : rt;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        r = 32'd0; o = 1'b0;
        case (op)
            3'd0, 3'd1: begin t = sa + sb; r = t[31:0];
                        o = (op == 3'd0) && (t > 64'sd2147483647 || t < -64'sd2147483648); end
            3'd2, 3'd3: begin t = sa - sb; r = t[31:0];
                        o = (op == 3'd2) && (t > 64'sd2147483647 || t < -64'sd2147483648); end
            3'd4: r = {31'd0, sa < sb};
            3'd5: r = {31'd0, a < b};
            default: ;
        endcase
    endtask

    task automatic run(input string req, input logic [2:0] op, input logic ui,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
        logic [31:0] er; logic eo;
        @(negedge clk);
        op_i = op; use_imm_i = ui; rs_i = a; rt_i = b; imm_i = im;
        @(posedge clk); #1;
        model(op, ui, a, b, im, er, eo);
        check(req, er, eo);
    endtask

    // run with a literal expectation in addition to the model
    task automatic run_lit(input string req, input logic [2:0] op, input logic ui,
                           input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                           input logic [31:0] er, input logic eo);
        run(req, op, ui, a, b, im);
        check(req, er, eo);
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1; op_i = 3'd0; rs_i = 32'h7fffffff; rt_i = 32'd1;
        @(posedge clk); #1;
        checks++;
        if (result_o !== 32'd0 || ovf_o !== 1'b0 || commit_ok_o !== 1'b0) begin
            failures++;
            $display("FAIL R9 reset: result=%h ovf=%b ok=%b expected 0 0 0", result_o, ovf_o, commit_ok_o);
        end
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_latency;
        // R9: output follows the operation presented before the edge, then the next one
        run_lit("R9 first", 3'd1, 0, 32'd5, 32'd7, 16'd0, 32'd12, 0);
        run_lit("R9 next",  3'd1, 0, 32'd100, 32'd1, 16'd0, 32'd101, 0);
    endtask

    task automatic t_add_overflow;
        run_lit("R2 add pos ovf", 3'd0, 0, 32'h7fffffff, 32'd1, 16'd0, 32'h80000000, 1);
        run_lit("R2 add neg ovf", 3'd0, 0, 32'h80000000, 32'hffffffff, 16'd0, 32'h7fffffff, 1);
        run_lit("R2 add no ovf",  3'd0, 0, 32'h7ffffffe, 32'd1, 16'd0, 32'h7fffffff, 0);
        run_lit("R2 sub ovf",     3'd2, 0, 32'd0, 32'h80000000, 16'd0, 32'h80000000, 1);
        run_lit("R2 sub no ovf",  3'd2, 0, 32'hffffffff, 32'h80000000, 16'd0, 32'h7fffffff, 0);
        run_lit("R2 sub neg ovf", 3'd2, 0, 32'h80000000, 32'd1, 16'd0, 32'h7fffffff, 1);
        run_lit("R4 addi ovf wraps", 3'd0, 1, 32'h7ffffff0, 32'd0, 16'h0010, 32'h80000000, 1);
    endtask

    task automatic t_unsigned_forms;
        run_lit("R3 addu no flag", 3'd1, 0, 32'h7fffffff, 32'd1, 16'd0, 32'h80000000, 0);
        run_lit("R3 subu no flag", 3'd3, 0, 32'h80000000, 32'd1, 16'd0, 32'h7fffffff, 0);
        run_lit("R4 unsigned wrap", 3'd1, 0, 32'hffffffff, 32'hffffffff, 16'd0, 32'hfffffffe, 0);
        run_lit("R3 addiu no flag", 3'd1, 1, 32'h80000000, 32'd0, 16'hffff, 32'h7fffffff, 0);
    endtask

    task automatic t_immediate;
        run_lit("R1 neg imm", 3'd1, 1, 32'd10, 32'd999, 16'hffff, 32'd9, 0);
        run_lit("R1 min imm", 3'd1, 1, 32'd0, 32'd0, 16'h8000, 32'hffff8000, 0);
        run_lit("R1 max imm", 3'd1, 1, 32'd0, 32'hffffffff, 16'h7fff, 32'h00007fff, 0);
        run_lit("R1 rt ignored", 3'd0, 1, 32'd1, 32'h7fffffff, 16'd2, 32'd3, 0);
    endtask

    task automatic t_slt;
        run_lit("R5 slt neg<pos", 3'd4, 0, 32'hffffffff, 32'd1, 16'd0, 32'd1, 0);
        run_lit("R5 slt pos>neg", 3'd4, 0, 32'd1, 32'hffffffff, 16'd0, 32'd0, 0);
        run_lit("R5 slt equal",   3'd4, 0, 32'd7, 32'd7, 16'd0, 32'd0, 0);
        run_lit("R5 slti",        3'd4, 1, 32'h80000000, 32'd0, 16'h8000, 32'd1, 0);
    endtask

    task automatic t_sltu;
        run_lit("R6 sltu big",   3'd5, 0, 32'hffffffff, 32'd1, 16'd0, 32'd0, 0);
        run_lit("R6 sltu small", 3'd5, 0, 32'd1, 32'hffffffff, 16'd0, 32'd1, 0);
        run_lit("R6 sltiu ext",  3'd5, 1, 32'h0000ffff, 32'd0, 16'hffff, 32'd1, 0);
        run_lit("R6 sltiu eq",   3'd5, 1, 32'hffff8000, 32'd0, 16'h8000, 32'd0, 0);
    endtask

    task automatic t_reserved;
        run_lit("R7 op6", 3'd6, 0, 32'h7fffffff, 32'd1, 16'd0, 32'd0, 0);
        run_lit("R7 op7", 3'd7, 1, 32'h12345678, 32'd1, 16'hffff, 32'd0, 0);
    endtask

    task automatic t_sweep;
        // R8: commit indication across many patterns, all codes and both forms
        logic [31:0] pats [8];
        pats = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff,
                 32'h40000000, 32'hc0000000, 32'h0000ffff};
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run("R8 sweep", op[2:0], j[0], pats[i], pats[j], pats[j][15:0] ^ 16'h8000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset;
        t_latency;
        t_add_overflow;
        t_unsigned_forms;
        t_immediate;
        t_slt;
        t_sltu;
        t_reserved;
        t_sweep;
        t_reset;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule